// File: doc/BRIEF.md
# Byte Accumulator Execute Stage

This block is the execute stage of a small accumulator-style processor. It holds a working register W, a file of byte-wide general registers and three status flags: carry, digit carry and zero. Each cycle it may accept one operation that has already been decoded. It can add W to a file register, AND W with a file register, AND W with a literal, clear or set one bit of a file register, or test one bit and ask the fetch stage to drop the next instruction when that bit is zero.

For the add and the register AND, a destination bit chooses the target. The result goes either to W or back to the addressed file register. A bit test that finds a zero raises a one-cycle skip request. The operation presented in that cycle is discarded as a no-op, so a taken test costs two cycles. The data width, the register count and the adder structure are parameters. The bench uses the default configuration.

Top module: `byte_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, W, every file register, the three flags and `skip_req` are cleared to zero.
- R2: Operation code 1 (add) forms W plus the addressed file register, modulo 256. With `in_dest`=0 the sum goes to W. With `in_dest`=1 it goes to the file register and W is unchanged.
- R3: The add sets carry to the carry out of bit 7, digit carry to the carry out of bit 3 into bit 4, and zero when the 8-bit sum is 0x00. Examples: 0x0F+0x01 gives C=0, DC=1, Z=0. 0xFF+0x01 gives C=1, DC=1, Z=1.
- R4: Operation code 2 (register AND) forms W AND the addressed file register and routes the result by `in_dest` in the same way as R2.
- R5: Both AND operations (codes 2 and 3) set zero when their result is 0x00 and leave carry and digit carry unchanged.
- R6: Operation code 3 (literal AND) writes W AND `in_lit` into W, whatever the value of `in_dest`, and changes no file register.
- R7: Operation code 4 clears, and code 5 sets, bit `in_bit` of the addressed file register. The other bits, W and all flags are unchanged.
- R8: Operation code 6 (bit test) writes nothing and changes no flag. If bit `in_bit` of the addressed register is 1, `skip_req` stays low. If it is 0, `skip_req` is high for exactly the following cycle.
- R9: An operation presented while `skip_req` is high is discarded. It writes no register and no flag, and it cannot start another skip.
- R10: With `in_valid` low, or with operation code 0 or 7, W, the file registers and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The operation fields are valid this cycle |
| in_op | input | 3 | Decoded operation code (0 none, 1 add, 2 register AND, 3 literal AND, 4 bit clear, 5 bit set, 6 bit test) |
| in_addr | input | 5 | File register address |
| in_dest | input | 1 | Destination: 0 = W, 1 = file register |
| in_bit | input | 3 | Bit index for the bit operations |
| in_lit | input | 8 | Literal operand |
| w_q | output | 8 | Working register W |
| c_flag | output | 1 | Carry flag |
| dc_flag | output | 1 | Digit carry flag |
| z_flag | output | 1 | Zero flag |
| skip_req | output | 1 | Tells fetch to discard the next instruction |

## Verification
The bench builds the block with its defaults: 8-bit data, 32 registers and the split nibble adder. At these sizes every W value can be swept against a set of file operands that reaches each flag corner, including 0x0F+0x01 and 0xFF+0x01. Every literal can be applied, and every bit position can be tested, cleared and set. File contents are read back only through the normal operations: a literal AND with 0x00, then an add into W. This lets both destination settings, the register left untouched by a squashed operation and the all-zero file after reset be checked at the ports.

// File: rtl/byte_exec_pkg.sv
package byte_exec_pkg;

   // Decoded operation codes accepted on in_op
   typedef enum logic [2:0] {
      OP_NONE      = 3'd0,
      OP_ADD_F     = 3'd1,
      OP_AND_F     = 3'd2,
      OP_AND_K     = 3'd3,
      OP_BIT_CLR   = 3'd4,
      OP_BIT_SET   = 3'd5,
      OP_TEST_SKIP = 3'd6
   } op_e;

   localparam int unsigned OP_W = 3;

   // Which state elements an operation updates
   typedef struct packed {
      logic wr_w;
      logic wr_f;
      logic upd_cdc;
      logic upd_z;
   } wr_ctl_t;

endpackage

// File: rtl/byte_exec_regfile.sv
module byte_exec_regfile #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned FLAT_W = DATA_W * DEPTH;

   if (DEPTH != (1 << AW)) begin : g_depth_chk
      $error("register file depth must be a power of two");
   end

   logic [FLAT_W-1:0] flat;

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      logic [DATA_W-1:0] row_q;
      logic              hit;

      assign hit = we && (waddr == AW'(i));

      always_ff @(posedge clk) begin
         if (rst) begin
            row_q <= '0;
         end else if (hit) begin
            row_q <= wdata;
         end
      end

      assign flat[i*DATA_W +: DATA_W] = row_q;
   end

   assign rdata = flat[raddr*DATA_W +: DATA_W];

endmodule

// File: rtl/byte_exec_alu.sv
module byte_exec_alu
   import byte_exec_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter bit          SPLIT_ADD = 1'b1,
   parameter int unsigned BW        = $clog2(DATA_W)
) (
   input  op_e               op,
   input  logic              dest,
   input  logic [DATA_W-1:0] w_val,
   input  logic [DATA_W-1:0] f_val,
   input  logic [BW-1:0]     bit_idx,
   input  logic [DATA_W-1:0] lit,
   output logic [DATA_W-1:0] result,
   output logic              c_next,
   output logic              dc_next,
   output logic              z_next,
   output wr_ctl_t           ctl,
   output logic              test_zero
);

   localparam int unsigned HALF = DATA_W / 2;
   localparam int unsigned HI_W = DATA_W - HALF;

   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_width_chk
      $error("data width must be even and at least 2");
   end

   logic [DATA_W-1:0] sum;
   logic              sum_carry;
   logic              sum_half;
   logic [DATA_W-1:0] mask;
   logic              sel_bit;

   // Adder variant: split nibble adder or single wide adder
   if (SPLIT_ADD) begin : g_split
      logic [HALF:0] lo;
      logic [HI_W:0] hi;
      assign lo = {1'b0, w_val[HALF-1:0]} + {1'b0, f_val[HALF-1:0]};
      assign hi = {1'b0, w_val[DATA_W-1:HALF]} + {1'b0, f_val[DATA_W-1:HALF]}
                + {{HI_W{1'b0}}, lo[HALF]};
      assign sum       = {hi[HI_W-1:0], lo[HALF-1:0]};
      assign sum_carry = hi[HI_W];
      assign sum_half  = lo[HALF];
   end else begin : g_wide
      logic [DATA_W:0] full;
      assign full      = {1'b0, w_val} + {1'b0, f_val};
      assign sum       = full[DATA_W-1:0];
      assign sum_carry = full[DATA_W];
      assign sum_half  = w_val[HALF] ^ f_val[HALF] ^ full[HALF];
   end

   assign mask    = {{(DATA_W-1){1'b0}}, 1'b1} << bit_idx;
   assign sel_bit = |(f_val & mask);

   always_comb begin
      result    = '0;
      c_next    = 1'b0;
      dc_next   = 1'b0;
      ctl       = '0;
      test_zero = 1'b0;
      unique case (op)
         OP_ADD_F: begin
            result      = sum;
            c_next      = sum_carry;
            dc_next     = sum_half;
            ctl.upd_cdc = 1'b1;
            ctl.upd_z   = 1'b1;
            ctl.wr_w    = ~dest;
            ctl.wr_f    = dest;
         end
         OP_AND_F: begin
            result    = w_val & f_val;
            ctl.upd_z = 1'b1;
            ctl.wr_w  = ~dest;
            ctl.wr_f  = dest;
         end
         OP_AND_K: begin
            result    = w_val & lit;
            ctl.upd_z = 1'b1;
            ctl.wr_w  = 1'b1;
         end
         OP_BIT_CLR: begin
            result   = f_val & ~mask;
            ctl.wr_f = 1'b1;
         end
         OP_BIT_SET: begin
            result   = f_val | mask;
            ctl.wr_f = 1'b1;
         end
         OP_TEST_SKIP: begin
            test_zero = ~sel_bit;
         end
         default: begin
         end
      endcase
   end

   assign z_next = (result == '0);

endmodule

// File: rtl/byte_exec_skip.sv
module byte_exec_skip (
   input  logic clk,
   input  logic rst,
   input  logic issue,
   input  logic take,
   output logic skip_q
);

   // One-cycle pulse after a taken test. The squashed slot cannot retrigger it.
   always_ff @(posedge clk) begin
      if (rst) begin
         skip_q <= 1'b0;
      end else begin
         skip_q <= issue & take;
      end
   end

endmodule

// File: rtl/byte_exec_unit.sv
module byte_exec_unit
   import byte_exec_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NREGS     = 32,
   parameter bit          SPLIT_ADD = 1'b1,
   parameter int unsigned AW        = $clog2(NREGS),
   parameter int unsigned BW        = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   in_op,
   input  logic [AW-1:0]     in_addr,
   input  logic              in_dest,
   input  logic [BW-1:0]     in_bit,
   input  logic [DATA_W-1:0] in_lit,
   output logic [DATA_W-1:0] w_q,
   output logic              c_flag,
   output logic              dc_flag,
   output logic              z_flag,
   output logic              skip_req
);

   op_e               op_d;
   logic              exec;
   logic [DATA_W-1:0] f_rd;
   logic [DATA_W-1:0] res;
   logic              c_n;
   logic              dc_n;
   logic              z_n;
   wr_ctl_t           ctl;
   logic              test_zero;

   assign op_d = op_e'(in_op);
   assign exec = in_valid & ~skip_req;

   byte_exec_regfile #(
      .DATA_W (DATA_W),
      .DEPTH  (NREGS),
      .AW     (AW)
   ) u_rf (
      .clk   (clk),
      .rst   (rst),
      .we    (exec & ctl.wr_f),
      .waddr (in_addr),
      .wdata (res),
      .raddr (in_addr),
      .rdata (f_rd)
   );

   byte_exec_alu #(
      .DATA_W    (DATA_W),
      .SPLIT_ADD (SPLIT_ADD),
      .BW        (BW)
   ) u_alu (
      .op        (op_d),
      .dest      (in_dest),
      .w_val     (w_q),
      .f_val     (f_rd),
      .bit_idx   (in_bit),
      .lit       (in_lit),
      .result    (res),
      .c_next    (c_n),
      .dc_next   (dc_n),
      .z_next    (z_n),
      .ctl       (ctl),
      .test_zero (test_zero)
   );

   byte_exec_skip u_skip (
      .clk    (clk),
      .rst    (rst),
      .issue  (exec),
      .take   (test_zero),
      .skip_q (skip_req)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         w_q     <= '0;
         c_flag  <= 1'b0;
         dc_flag <= 1'b0;
         z_flag  <= 1'b0;
      end else if (exec) begin
         if (ctl.wr_w) begin
            w_q <= res;
         end
         if (ctl.upd_cdc) begin
            c_flag  <= c_n;
            dc_flag <= dc_n;
         end
         if (ctl.upd_z) begin
            z_flag <= z_n;
         end
      end
   end

endmodule

// File: rtl/byte_exec_unit_chk.sv
module byte_exec_unit_chk
   import byte_exec_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NREGS     = 32,
   parameter bit          SPLIT_ADD = 1'b1,
   parameter int unsigned AW        = $clog2(NREGS),
   parameter int unsigned BW        = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [OP_W-1:0]   in_op,
   input logic [AW-1:0]     in_addr,
   input logic              in_dest,
   input logic [BW-1:0]     in_bit,
   input logic [DATA_W-1:0] in_lit,
   input logic [DATA_W-1:0] w_q,
   input logic              c_flag,
   input logic              dc_flag,
   input logic              z_flag,
   input logic              skip_req
);

   logic live;
   assign live = in_valid & ~skip_req;

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (w_q == '0 && !c_flag && !dc_flag && !z_flag && !skip_req)); // R1

   AST_ADD_TO_FILE_KEEPS_W: assert property (@(posedge clk) disable iff (rst)
      (live && in_op == OP_ADD_F && in_dest) |=> $stable(w_q)); // R2

   AST_AND_KEEPS_CARRIES: assert property (@(posedge clk) disable iff (rst)
      (live && (in_op == OP_AND_F || in_op == OP_AND_K)) |=> ($stable(c_flag) && $stable(dc_flag))); // R5

   AST_AND_K_RESULT: assert property (@(posedge clk) disable iff (rst)
      (live && in_op == OP_AND_K) |=> (w_q == ($past(w_q) & $past(in_lit)) && z_flag == (w_q == '0))); // R6

   AST_BITOPS_QUIET: assert property (@(posedge clk) disable iff (rst)
      (live && (in_op == OP_BIT_CLR || in_op == OP_BIT_SET || in_op == OP_TEST_SKIP))
      |=> ($stable(w_q) && $stable({c_flag, dc_flag, z_flag}))); // R7

   AST_SKIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      skip_req |=> !skip_req); // R8

   AST_SKIP_FROM_TEST: assert property (@(posedge clk) disable iff (rst)
      $rose(skip_req) |-> $past(live && in_op == OP_TEST_SKIP)); // R8

   AST_SQUASH_HOLDS: assert property (@(posedge clk) disable iff (rst)
      skip_req |=> ($stable(w_q) && $stable({c_flag, dc_flag, z_flag}))); // R9

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!in_valid || in_op == OP_NONE || in_op == 3'd7) |=> ($stable(w_q) && $stable({c_flag, dc_flag, z_flag}))); // R10

endmodule

bind byte_exec_unit byte_exec_unit_chk #(
   .DATA_W    (DATA_W),
   .NREGS     (NREGS),
   .SPLIT_ADD (SPLIT_ADD),
   .AW        (AW),
   .BW        (BW)
) u_chk (.*);

// File: tb/tb_byte_exec_unit.sv
`timescale 1ns/1ps
module tb_byte_exec_unit;

   localparam logic [2:0] C_NONE = 3'd0, C_ADD = 3'd1, C_ANDF = 3'd2, C_ANDK = 3'd3,
                          C_BCLR = 3'd4, C_BSET = 3'd5, C_TEST = 3'd6;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [2:0] in_op = '0;
   logic [4:0] in_addr = '0;
   logic       in_dest = 1'b0;
   logic [2:0] in_bit = '0;
   logic [7:0] in_lit = '0;
   logic [7:0] w_q;
   logic       c_flag, dc_flag, z_flag, skip_req;

   int nchk = 0;
   int nfail = 0;

   // Reference state
   logic [7:0] m_w;
   logic [7:0] m_f [32];
   logic       m_c, m_dc, m_z, m_skip;

   always #2.5 clk = ~clk;

   byte_exec_unit dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_addr(in_addr),
      .in_dest(in_dest), .in_bit(in_bit), .in_lit(in_lit), .w_q(w_q),
      .c_flag(c_flag), .dc_flag(dc_flag), .z_flag(z_flag), .skip_req(skip_req)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic v, input logic [2:0] op, input logic [4:0] a,
                         input logic d, input logic [2:0] b, input logic [7:0] k);
      logic [8:0] s;
      logic [7:0] r;
      logic       ex, nsk;
      string      wt, ft;
      in_valid = v; in_op = op; in_addr = a; in_dest = d; in_bit = b; in_lit = k;
      ex  = v && !m_skip;
      nsk = 1'b0;
      wt = "R10"; ft = "R10";
      if (v && m_skip) begin wt = "R9"; ft = "R9"; end
      if (ex) begin
         case (op)
            C_ADD: begin
               s = {1'b0, m_w} + {1'b0, m_f[a]};
               r = s[7:0];
               m_c  = s[8];
               m_dc = ({1'b0, m_w[3:0]} + {1'b0, m_f[a][3:0]}) > 5'd15;
               m_z  = (r == 8'h00);
               if (d) m_f[a] = r; else m_w = r;
               wt = "R2"; ft = "R3";
            end
            C_ANDF: begin
               r = m_w & m_f[a];
               m_z = (r == 8'h00);
               if (d) m_f[a] = r; else m_w = r;
               wt = "R4"; ft = "R5";
            end
            C_ANDK: begin
               m_w = m_w & k;
               m_z = (m_w == 8'h00);
               wt = "R6"; ft = "R5";
            end
            C_BCLR: begin m_f[a][b] = 1'b0; wt = "R7"; ft = "R7"; end
            C_BSET: begin m_f[a][b] = 1'b1; wt = "R7"; ft = "R7"; end
            C_TEST: begin nsk = !m_f[a][b]; wt = "R8"; ft = "R8"; end
            default: begin end
         endcase
      end
      m_skip = nsk;
      @(posedge clk);
      @(negedge clk);
      check(wt, "W", w_q, m_w);
      check(ft, "flags", {c_flag, dc_flag, z_flag}, {m_c, m_dc, m_z});
      check((op == C_TEST || m_skip) ? "R8" : wt, "skip", skip_req, m_skip);
   endtask

   task automatic load_reg(input logic [4:0] a, input logic [7:0] v);
      for (int i = 0; i < 8; i++) run_op(1'b1, v[i] ? C_BSET : C_BCLR, a, 1'b0, 3'(i), 8'h00);
   endtask

   task automatic load_w(input logic [7:0] v);
      load_reg(5'd30, v);
      run_op(1'b1, C_ANDK, 5'd0, 1'b0, 3'd0, 8'h00);
      run_op(1'b1, C_ADD, 5'd30, 1'b0, 3'd0, 8'h00);
   endtask

   // File readback through normal operations: W = 0, then W = f
   task automatic read_reg(input logic [4:0] a, input logic [7:0] exp, input string req);
      run_op(1'b1, C_ANDK, 5'd0, 1'b0, 3'd0, 8'h00);
      run_op(1'b1, C_ADD, a, 1'b0, 3'd0, 8'h00);
      check(req, "file readback", w_q, exp);
   endtask

   initial begin
      #(190000 * 5);
      nfail++;
      $display("FAIL watchdog R10: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

   initial begin
      logic [7:0] ops [8];
      ops = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hF0, 8'hFF};
      m_w = '0; m_c = 0; m_dc = 0; m_z = 0; m_skip = 0;
      for (int i = 0; i < 32; i++) m_f[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      check("R1", "W", w_q, 0);
      check("R1", "flags", {c_flag, dc_flag, z_flag}, 0);
      check("R1", "skip", skip_req, 0);
      for (int i = 0; i < 32; i++) read_reg(5'(i), 8'h00, "R1");

      // R3 directed flag corners
      load_reg(5'd2, 8'h01);
      load_w(8'h0F);
      run_op(1'b1, C_ADD, 5'd2, 1'b0, 3'd0, 8'h00);
      check("R3", "0F+01", {w_q, c_flag, dc_flag, z_flag}, {8'h10, 3'b010});
      load_w(8'hFF);
      run_op(1'b1, C_ADD, 5'd2, 1'b0, 3'd0, 8'h00);
      check("R3", "FF+01", {w_q, c_flag, dc_flag, z_flag}, {8'h00, 3'b111});

      // R2 R3 add sweep over all W values, both destinations
      for (int a = 0; a < 256; a++) begin
         for (int j = 0; j < 8; j++) begin
            logic dd;
            dd = 1'(j) ^ 1'(a);
            load_reg(5'd1, ops[j]);
            load_w(8'(a));
            run_op(1'b1, C_ADD, 5'd1, dd, 3'd0, 8'h00);
            if (dd) read_reg(5'd1, 8'((a + ops[j]) & 255), "R2");
         end
      end

      // R4 R5 register AND sweep
      for (int a = 0; a < 256; a += 3) begin
         for (int j = 0; j < 8; j++) begin
            logic dd;
            dd = 1'(j) ^ 1'(a);
            load_reg(5'd3, ops[j]);
            load_w(8'(a));
            run_op(1'b1, C_ANDF, 5'd3, dd, 3'd0, 8'h00);
            if (dd) read_reg(5'd3, 8'(a) & ops[j], "R4");
         end
      end

      // R6 literal AND: every literal, dest set high, file unchanged
      load_reg(5'd4, 8'h5A);
      for (int k = 0; k < 256; k++) begin
         load_w((k % 2 == 0) ? 8'hA5 : 8'hFF);
         run_op(1'b1, C_ANDK, 5'd4, 1'b1, 3'd0, 8'(k));
      end
      read_reg(5'd4, 8'h5A, "R6");

      // R7 bit clear / set on every bit
      for (int b = 0; b < 8; b++) begin
         load_reg(5'd5, 8'hFF);
         run_op(1'b1, C_BCLR, 5'd5, 1'b0, 3'(b), 8'h00);
         read_reg(5'd5, 8'hFF & ~(8'h01 << b), "R7");
         load_reg(5'd5, 8'h00);
         run_op(1'b1, C_BSET, 5'd5, 1'b0, 3'(b), 8'h00);
         read_reg(5'd5, 8'h01 << b, "R7");
      end

      // R8 R9 bit test both outcomes; next op would write reg 6 if not squashed
      for (int b = 0; b < 8; b++) begin
         load_reg(5'd7, 8'hA5);
         load_reg(5'd6, 8'h11);
         load_w(8'h22);
         run_op(1'b1, C_TEST, 5'd7, 1'b0, 3'(b), 8'h00);
         run_op(1'b1, C_ADD, 5'd6, 1'b1, 3'd0, 8'h00);
         check("R8", "post-skip low", skip_req, 0);
         read_reg(5'd6, ((8'hA5 >> b) & 1) ? 8'h33 : 8'h11, "R9");
      end
      // squashed test cannot chain a skip
      load_reg(5'd7, 8'h00);
      run_op(1'b1, C_TEST, 5'd7, 1'b0, 3'd0, 8'h00);
      run_op(1'b1, C_TEST, 5'd7, 1'b0, 3'd1, 8'h00);
      check("R9", "no chained skip", skip_req, 0);

      // R10 invalid strobe and no-op codes
      load_reg(5'd8, 8'h3C);
      load_w(8'h81);
      run_op(1'b0, C_ADD, 5'd8, 1'b1, 3'd0, 8'h00);
      run_op(1'b0, C_BCLR, 5'd8, 1'b0, 3'd2, 8'h00);
      run_op(1'b1, C_NONE, 5'd8, 1'b1, 3'd2, 8'h00);
      run_op(1'b1, 3'd7, 5'd8, 1'b1, 3'd2, 8'h00);
      check("R10", "W held", w_q, 8'h81);
      read_reg(5'd8, 8'h3C, "R10");

      in_valid = 1'b0;
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

endmodule